// File: doc/BRIEF.md
# Calendar Alarm Match Unit

This block watches the live calendar of a real-time clock and raises an alarm when the calendar reaches a programmed moment. Software programs six alarm fields: seconds, minutes, hours, date, month and day of week. Each field holds a BCD compare value and an enable bit. A field that is not enabled is left out of the compare, so it matches any value. The compare runs only on the cycle in which the timekeeper reports that time has advanced. The timekeeper presents the new calendar values together with that strobe.

When an alarm fires, a sticky alarm flag is set and an active-low interrupt pin is driven. A two-bit control register selects the interrupt behaviour. In level mode the pin stays low until software clears the flag. In pulsed mode each match gives a low pulse of fixed length. Repeated alarms then keep arriving without any software action, for example once a minute when only the seconds field is enabled.

Top module: `cal_alarm`

## Requirements
- R1: After reset, `almFlag` is 0 and `irqN` is 1. All six alarm fields are disabled, and the control register is 0 (alarm off, level mode).
- R2: An alarm field write puts `almWrData[7]` in the field's enable bit and `almWrData[6:0]` in its compare value. An enabled field matches when the current value equals the compare value zero-extended to 8 bits. A disabled field always matches.
- R3: The match is evaluated only in a cycle with `tickStb` high. A calendar that matches without the strobe sets nothing.
- R4: When no field is enabled, no tick produces an alarm.
- R5: A tick on which every field matches, with the alarm enabled (`ctlWrData[1]` = 1), sets `almFlag` at the next clock edge.
- R6: In level mode (`ctlWrData[0]` = 0), `irqN` is low while `almFlag` is set. `statusClr` clears the flag and releases `irqN` at the next edge. A new match in the same cycle as the clear wins, and the flag stays set.
- R7: In pulsed mode (`ctlWrData[0]` = 1), each triggering tick drives `irqN` low for exactly `PULSE_CYC` cycles, starting at the next edge. Later matches pulse again with no clear of `almFlag`. `almFlag` is still set on each trigger.
- R8: While the alarm enable is 0, `almFlag` never sets and `irqN` stays high, whatever the compare result.
- R9: `almWrSel` selects the field: 0 seconds, 1 minutes, 2 hours, 3 date, 4 month, 5 day of week. Select values 6 and 7 write nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| tickStb | input | 1 | One-cycle strobe: calendar has advanced |
| curSec | input | 8 | Current seconds, BCD |
| curMin | input | 8 | Current minutes, BCD |
| curHour | input | 8 | Current hours, BCD |
| curDate | input | 8 | Current date, BCD |
| curMonth | input | 8 | Current month, BCD |
| curDow | input | 8 | Current day of week |
| almWrEn | input | 1 | Alarm field write strobe |
| almWrSel | input | 3 | Alarm field select |
| almWrData | input | 8 | Enable bit and BCD compare value |
| ctlWrEn | input | 1 | Control register write strobe |
| ctlWrData | input | 2 | [1] alarm enable, [0] pulsed mode |
| statusClr | input | 1 | Clear the alarm flag |
| almFlag | output | 1 | Sticky alarm status |
| irqN | output | 1 | Active-low interrupt |

## Verification
The bound checker checks these on every cycle:
- the flag never rises without a tick;
- a qualified match always sets the flag;
- level mode ties the pin to the flag;
- a clear with no competing trigger empties the flag;
- a disabled alarm keeps the pin high.

Only the directed scenarios can show the following:
- the field encoding and select mapping;
- the wildcard effect of disabled fields;
- that the all-disabled case stays silent;
- the exact pulse length;
- that repeated pulses need no clear;
- that out-of-range selects leave the programmed fields intact.

// File: rtl/alm_pkg.sv
package alm_pkg;
  localparam int NUM_FIELDS = 6;
  localparam int FIELD_W = 8;
  localparam int SEL_W = $clog2(NUM_FIELDS);

  typedef struct packed {
    logic [NUM_FIELDS-1:0] fieldWe;
    logic ctlWe;
  } almStrobe_t;
endpackage

// File: rtl/alm_datapath.sv
module alm_datapath
  import alm_pkg::*;
(
  input  logic clk,
  input  logic rstN,
  input  almStrobe_t strobe,
  input  logic [FIELD_W-1:0] wrData,
  input  logic [1:0] ctlData,
  input  logic [NUM_FIELDS-1:0][FIELD_W-1:0] curFields,
  output logic hit,
  output logic almEn,
  output logic pulseMode
);
  localparam int VAL_W = FIELD_W - 1;

  logic [NUM_FIELDS-1:0] fieldEn;
  logic [NUM_FIELDS-1:0] fieldOk;
  logic [NUM_FIELDS-1:0][VAL_W-1:0] fieldVal;

  for (genvar i = 0; i < NUM_FIELDS; i++) begin : g_field
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        fieldEn[i] <= 1'b0;
        fieldVal[i] <= '0;
      end else if (strobe.fieldWe[i]) begin
        fieldEn[i] <= wrData[FIELD_W-1];
        fieldVal[i] <= wrData[VAL_W-1:0];
      end
    end
    assign fieldOk[i] = !fieldEn[i] || (curFields[i] == {1'b0, fieldVal[i]});
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      almEn <= 1'b0;
      pulseMode <= 1'b0;
    end else if (strobe.ctlWe) begin
      almEn <= ctlData[1];
      pulseMode <= ctlData[0];
    end
  end

  assign hit = (&fieldOk) && (|fieldEn);
endmodule

// File: rtl/alm_control.sv
module alm_control
  import alm_pkg::*;
#(
  parameter int PULSE_CYC = 4
) (
  input  logic clk,
  input  logic rstN,
  input  logic tickStb,
  input  logic almWrEn,
  input  logic [SEL_W-1:0] almWrSel,
  input  logic ctlWrEn,
  input  logic statusClr,
  input  logic hit,
  input  logic almEn,
  input  logic pulseMode,
  output almStrobe_t strobe,
  output logic almFlag,
  output logic irqN
);
  localparam int CNT_W = $clog2(PULSE_CYC + 1);

  logic trigger;
  logic [CNT_W-1:0] pulseCnt;

  for (genvar i = 0; i < NUM_FIELDS; i++) begin : g_we
    assign strobe.fieldWe[i] = almWrEn && (almWrSel == SEL_W'(i));
  end
  assign strobe.ctlWe = ctlWrEn;

  assign trigger = tickStb && hit && almEn;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) almFlag <= 1'b0;
    else if (trigger) almFlag <= 1'b1;
    else if (statusClr) almFlag <= 1'b0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pulseCnt <= '0;
    else if (trigger && pulseMode) pulseCnt <= CNT_W'(PULSE_CYC);
    else if (pulseCnt != '0) pulseCnt <= pulseCnt - 1'b1;
  end

  assign irqN = !(almEn && (pulseMode ? (pulseCnt != '0) : almFlag));
endmodule

// File: rtl/cal_alarm.sv
module cal_alarm
  import alm_pkg::*;
#(
  parameter int PULSE_CYC = 4
) (
  input  logic clk,
  input  logic rstN,
  input  logic tickStb,
  input  logic [7:0] curSec,
  input  logic [7:0] curMin,
  input  logic [7:0] curHour,
  input  logic [7:0] curDate,
  input  logic [7:0] curMonth,
  input  logic [7:0] curDow,
  input  logic almWrEn,
  input  logic [2:0] almWrSel,
  input  logic [7:0] almWrData,
  input  logic ctlWrEn,
  input  logic [1:0] ctlWrData,
  input  logic statusClr,
  output logic almFlag,
  output logic irqN
);
  almStrobe_t strobe;
  logic hit, almEn, pulseMode;
  logic [NUM_FIELDS-1:0][FIELD_W-1:0] curFields;

  assign curFields = {curDow, curMonth, curDate, curHour, curMin, curSec};

  alm_control #(.PULSE_CYC(PULSE_CYC)) u_ctl (
    .clk(clk), .rstN(rstN), .tickStb(tickStb),
    .almWrEn(almWrEn), .almWrSel(almWrSel), .ctlWrEn(ctlWrEn),
    .statusClr(statusClr), .hit(hit), .almEn(almEn), .pulseMode(pulseMode),
    .strobe(strobe), .almFlag(almFlag), .irqN(irqN)
  );

  alm_datapath u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrData(almWrData),
    .ctlData(ctlWrData), .curFields(curFields),
    .hit(hit), .almEn(almEn), .pulseMode(pulseMode)
  );
endmodule

// File: rtl/alm_checker.sv
module alm_checker (
  input logic clk,
  input logic rstN,
  input logic tickStb,
  input logic statusClr,
  input logic hit,
  input logic almEn,
  input logic pulseMode,
  input logic almFlag,
  input logic irqN
);
  a_r3_no_tick_no_set: assert property (@(posedge clk) disable iff (!rstN)
    !tickStb |=> !$rose(almFlag));

  a_r5_match_sets: assert property (@(posedge clk) disable iff (!rstN)
    (tickStb && hit && almEn) |=> almFlag);

  a_r6_level_pin: assert property (@(posedge clk) disable iff (!rstN)
    (almEn && !pulseMode && almFlag) |-> !irqN);

  a_r6_clear: assert property (@(posedge clk) disable iff (!rstN)
    (statusClr && !(tickStb && hit && almEn)) |=> !almFlag);

  a_r8_off_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !almEn |-> irqN);
endmodule

bind cal_alarm alm_checker u_chk (
  .clk(clk), .rstN(rstN), .tickStb(tickStb), .statusClr(statusClr),
  .hit(hit), .almEn(almEn), .pulseMode(pulseMode),
  .almFlag(almFlag), .irqN(irqN)
);

// File: tb/sim_cal_alarm.sv
module sim_cal_alarm;
  localparam int PULSE_CYC = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic tickStb = 1'b0;
  logic [7:0] curSec = '0, curMin = '0, curHour = '0, curDate = '0, curMonth = '0, curDow = '0;
  logic almWrEn = 1'b0;
  logic [2:0] almWrSel = '0;
  logic [7:0] almWrData = '0;
  logic ctlWrEn = 1'b0;
  logic [1:0] ctlWrData = '0;
  logic statusClr = 1'b0;
  logic almFlag, irqN;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  cal_alarm #(.PULSE_CYC(PULSE_CYC)) u0 (
    .clk(clk), .rstN(rstN), .tickStb(tickStb),
    .curSec(curSec), .curMin(curMin), .curHour(curHour), .curDate(curDate),
    .curMonth(curMonth), .curDow(curDow),
    .almWrEn(almWrEn), .almWrSel(almWrSel), .almWrData(almWrData),
    .ctlWrEn(ctlWrEn), .ctlWrData(ctlWrData), .statusClr(statusClr),
    .almFlag(almFlag), .irqN(irqN)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wrField(input int sel, input logic [7:0] data);
    almWrEn = 1'b1; almWrSel = 3'(sel); almWrData = data;
    @(negedge clk);
    almWrEn = 1'b0;
  endtask

  task automatic wrCtl(input logic [1:0] data);
    ctlWrEn = 1'b1; ctlWrData = data;
    @(negedge clk);
    ctlWrEn = 1'b0;
  endtask

  task automatic setTime(input logic [7:0] s, m, h, d, mo, w);
    curSec = s; curMin = m; curHour = h; curDate = d; curMonth = mo; curDow = w;
  endtask

  task automatic tick();
    tickStb = 1'b1;
    @(negedge clk);
    tickStb = 1'b0;
  endtask

  task automatic clearFlag();
    statusClr = 1'b1;
    @(negedge clk);
    statusClr = 1'b0;
  endtask

  task automatic clearFields();
    for (int i = 0; i < 6; i++) wrField(i, 8'h00);
  endtask

  task automatic testReset();
    chk("R1 flag after reset", almFlag, 0);
    chk("R1 irq after reset", irqN, 1);
  endtask

  task automatic testNoFields();
    wrCtl(2'b10);
    setTime(8'h00, 8'h00, 8'h00, 8'h01, 8'h01, 8'h01);
    tick();
    chk("R4 no field enabled", almFlag, 0);
  endtask

  task automatic testLevel();
    wrField(0, 8'hB0);
    wrField(1, 8'h95);
    setTime(8'h30, 8'h14, 8'h11, 8'h01, 8'h01, 8'h02);
    tick();
    chk("R2 minutes mismatch", almFlag, 0);
    setTime(8'h30, 8'h15, 8'h11, 8'h01, 8'h01, 8'h02);
    repeat (2) @(negedge clk);
    chk("R3 match without tick", almFlag, 0);
    tick();
    chk("R5 flag set on match", almFlag, 1);
    chk("R6 level irq low", irqN, 0);
    repeat (3) @(negedge clk);
    chk("R6 irq held low", irqN, 0);
    clearFlag();
    chk("R6 clear flag", almFlag, 0);
    chk("R6 clear releases irq", irqN, 1);
    statusClr = 1'b1;
    tick();
    statusClr = 1'b0;
    chk("R6 set wins over clear", almFlag, 1);
    clearFlag();
  endtask

  task automatic testBadSel();
    wrField(6, 8'hFF);
    wrField(7, 8'hFF);
    tick();
    chk("R9 select 6/7 ignored", almFlag, 1);
    clearFlag();
  endtask

  task automatic testAllFields();
    logic [7:0] vals [6];
    vals = '{8'h45, 8'h27, 8'h13, 8'h28, 8'h11, 8'h04};
    for (int i = 0; i < 6; i++) wrField(i, vals[i] | 8'h80);
    for (int k = 0; k < 6; k++) begin
      logic [7:0] t [6];
      t = vals;
      t[k] = t[k] ^ 8'h01;
      setTime(t[0], t[1], t[2], t[3], t[4], t[5]);
      tick();
      chk($sformatf("R9 field %0d mismatch blocks", k), almFlag, 0);
    end
    setTime(vals[0], vals[1], vals[2], vals[3], vals[4], vals[5]);
    tick();
    chk("R2 all six fields match", almFlag, 1);
    clearFlag();
    clearFields();
  endtask

  task automatic testPulse();
    int lowCnt;
    wrField(0, 8'hB0);
    wrCtl(2'b11);
    setTime(8'h30, 8'h02, 8'h09, 8'h05, 8'h03, 8'h01);
    for (int rep = 0; rep < 2; rep++) begin
      tick();
      chk("R7 flag set in pulsed mode", almFlag, 1);
      lowCnt = 0;
      for (int c = 0; c < PULSE_CYC + 3; c++) begin
        if (!irqN) lowCnt++;
        @(negedge clk);
      end
      chk("R7 pulse width", lowCnt, PULSE_CYC);
      chk("R7 irq released", irqN, 1);
    end
    clearFlag();
  endtask

  task automatic testDisabled();
    wrCtl(2'b00);
    tick();
    chk("R8 disabled no flag", almFlag, 0);
    chk("R8 disabled irq high", irqN, 1);
    wrCtl(2'b01);
    tick();
    chk("R8 disabled pulsed no flag", almFlag, 0);
    chk("R8 disabled pulsed irq high", irqN, 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testNoFields();
    testLevel();
    testBadSel();
    clearFields();
    testAllFields();
    testPulse();
    testDisabled();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule